// File: doc/BRIEF.md
# Bypassable Linear Score Reduction Chain

This block merges the per-core results of a parallel order-scoring engine into two totals for the sampling controller: a log-domain order score and a best-graph score, together with the assembled graph itself (one chosen parent set per node). Cores are grouped into nodes. Reduction walks a nearest-neighbour chain of registered stages. It first folds the cores of one node together, then adds that node's result into the running total before passing it to the next node. Cores that are not enabled are passed over at run time, and so are whole nodes with no active core. One fixed hardware build can therefore serve any smaller problem.

Two chains run side by side. The order chain folds the core log-sums inside a node with a log-domain addition, then adds node scores. The graph chain keeps, per node, the best parent set reported by its cores. At the end of each node it spends one extra stage writing that set into the graph vector and adding its score. The graph result therefore trails the order result by one cycle per node. It is assembled while the next order is already flowing through the order chain. Each result carries a sequence tag so the controller can pair the graph with its order.

Top module: `score_chain_reducer`

## Requirements
- R1: After reset, `order_valid` and `graph_valid` are low and `order_score`, `graph_score` and `graph_sets` are zero.
- R2: A launch is any clock edge at which some bit of `core_vld` is high. Exactly S = N_NODES*N_CORES cycles after the launch edge, `order_valid` is high for one cycle. `order_tag` is the number of earlier launches since reset, modulo 2^TAG_W.
- R3: A node's score folds the log-sums of its active cores in ascending core index: acc = first sum, then acc = max(acc,x) + k. Here k is 2 when the two values are equal, 1 when they differ by 1 to 3, and 0 otherwise.
- R4: `order_score` is the two's-complement sum of the scores of every node that has at least one active core. Core k = n*N_CORES + c occupies bits [k*SCORE_W +: SCORE_W] of `core_sum`.
- R5: Core k is active only when both `core_en[k]` and `core_vld[k]` are high. An inactive core changes neither the order score nor the graph outputs.
- R6: A node's chosen parent set comes from the active core with the largest `core_bscore`; the lower core index wins a tie. It is placed at bits [n*PSET_W +: PSET_W] of `graph_sets`. A node with no active core gives zero there.
- R7: `graph_score` is the sum over active nodes of the best score chosen for each node.
- R8: `graph_valid` pulses S + N_NODES cycles after the launch edge, and `graph_tag` equals the tag of the same order. Launches on consecutive cycles each yield their own results, in launch order.
- R9: A launch with no active core gives `order_err` high with `order_score` zero, and a graph result with zero score and all parent-set fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_vld | input | S | Per-core result valid |
| core_en | input | S | Per-core run-time enable |
| core_sum | input | S*SCORE_W | Per-core signed log-sum of compatible parent sets |
| core_bset | input | S*PSET_W | Per-core best parent set identifier |
| core_bscore | input | S*SCORE_W | Per-core signed score of that best set |
| order_valid | output | 1 | Order result strobe |
| order_score | output | SCORE_W | Signed log-domain order score |
| order_err | output | 1 | No active core in this order |
| order_tag | output | TAG_W | Sequence tag of the order result |
| graph_valid | output | 1 | Graph result strobe |
| graph_score | output | SCORE_W | Signed best-graph score |
| graph_sets | output | N_NODES*PSET_W | Chosen parent set per node |
| graph_tag | output | TAG_W | Sequence tag of the graph result |

## Verification
With the default 3 nodes of 2 cores, the order result is due 6 cycles after the launch edge and the graph result 9 cycles after it. Bypassed stages still cost their cycle, so these figures do not depend on the enable pattern. Each check samples on the falling edge of the due cycle. It also confirms that the strobe was still low one cycle earlier, so an early or late result is caught. For three launches on consecutive cycles, the bench reads the three order results and then the three graph results on successive falling edges and matches each against its own tag.

// File: rtl/scr_pkg.sv
// Shared helpers for the score reduction chain.
// Assumes scores are signed fixed-point log values that fit in 32 bits.
package scr_pkg;
    localparam int CORR_EQUAL = 2;
    localparam int CORR_NEAR  = 1;
    localparam int NEAR_SPAN  = 3;

    // Approximate log-domain addition: larger operand plus a small correction.
    function automatic int log_add(input int a, input int b);
        int hi;
        int gap;
        int corr;
        hi   = (a > b) ? a : b;
        gap  = (a > b) ? a - b : b - a;
        if (gap == 0)              corr = CORR_EQUAL;
        else if (gap <= NEAR_SPAN) corr = CORR_NEAR;
        else                       corr = 0;
        return hi + corr;
    endfunction
endpackage

// File: rtl/scr_delay.sv
// Fixed delay line that aligns one core's result with its chain stage.
// Assumes DEPTH is small; DEPTH of zero is a plain wire.
module scr_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] taps [DEPTH];
            // Shift the payload one tap per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= din;
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end
            assign dout = taps[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/scr_order_stage.sv
// One registered hop of the order-score chain. Folds one core's log-sum into
// the running node value; the last core of a node also adds the node into the
// order total and clears the node value. Assumes core data is pre-aligned.
module scr_order_stage
    import scr_pkg::*;
#(
    parameter int SW   = 16,
    parameter int TW   = 4,
    parameter bit LAST = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [TW-1:0]        in_tag,
    input  logic signed [SW-1:0] in_acc,
    input  logic                 in_on,
    input  logic signed [SW-1:0] in_tot,
    input  logic                 in_any,
    input  logic                 core_act,
    input  logic signed [SW-1:0] core_sum,
    output logic                 out_vld,
    output logic [TW-1:0]        out_tag,
    output logic signed [SW-1:0] out_acc,
    output logic                 out_on,
    output logic signed [SW-1:0] out_tot,
    output logic                 out_any
);
    logic signed [SW-1:0] nx_acc, nx_tot, node_val;
    logic                 nx_on, nx_any, node_on;
    int                   folded;

    // Fold the core into the node, and close the node on its last core.
    always_comb begin
        folded   = log_add(int'(in_acc), int'(core_sum));
        node_val = core_act ? (in_on ? SW'(folded) : core_sum) : in_acc;
        node_on  = in_on | core_act;
        if (LAST) begin
            nx_tot = node_on ? in_tot + node_val : in_tot;
            nx_any = in_any | node_on;
            nx_acc = '0;
            nx_on  = 1'b0;
        end else begin
            nx_tot = in_tot;
            nx_any = in_any;
            nx_acc = node_val;
            nx_on  = node_on;
        end
    end

    // Register the hop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_tag <= '0;
            out_acc <= '0;
            out_on  <= 1'b0;
            out_tot <= '0;
            out_any <= 1'b0;
        end else begin
            out_vld <= in_vld;
            out_tag <= in_tag;
            out_acc <= nx_acc;
            out_on  <= nx_on;
            out_tot <= nx_tot;
            out_any <= nx_any;
        end
    end

    generate
        if (!LAST) begin : g_chk
            // R3: a fold never yields less than either operand.
            a_r3_fold_ge_operands: assert property (@(posedge clk) disable iff (!rst_n)
                (core_act && in_on) |=> (out_acc >= $past(in_acc) && out_acc >= $past(core_sum)));
        end
    endgenerate
endmodule

// File: rtl/scr_best_stage.sv
// One registered hop of the graph chain for one core: keeps the best parent
// set seen so far in the current node (strictly greater replaces, so earlier
// cores win ties). Assumes core data is pre-aligned to this hop.
module scr_best_stage #(
    parameter int SW = 16,
    parameter int PW = 8,
    parameter int TW = 4,
    parameter int GW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [TW-1:0]        in_tag,
    input  logic signed [SW-1:0] in_tot,
    input  logic [GW-1:0]        in_vec,
    input  logic                 in_bon,
    input  logic signed [SW-1:0] in_bsc,
    input  logic [PW-1:0]        in_bset,
    input  logic                 core_act,
    input  logic signed [SW-1:0] core_bsc,
    input  logic [PW-1:0]        core_bset,
    output logic                 out_vld,
    output logic [TW-1:0]        out_tag,
    output logic signed [SW-1:0] out_tot,
    output logic [GW-1:0]        out_vec,
    output logic                 out_bon,
    output logic signed [SW-1:0] out_bsc,
    output logic [PW-1:0]        out_bset
);
    logic take;

    // Decide whether this core beats the node's current best.
    always_comb take = core_act && (!in_bon || core_bsc > in_bsc);

    // Register the hop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_tag  <= '0;
            out_tot  <= '0;
            out_vec  <= '0;
            out_bon  <= 1'b0;
            out_bsc  <= '0;
            out_bset <= '0;
        end else begin
            out_vld  <= in_vld;
            out_tag  <= in_tag;
            out_tot  <= in_tot;
            out_vec  <= in_vec;
            out_bon  <= in_bon | core_act;
            out_bsc  <= take ? core_bsc : in_bsc;
            out_bset <= take ? core_bset : in_bset;
        end
    end

    // R6: after an active core the node best is at least that core's score.
    a_r6_best_ge_core: assert property (@(posedge clk) disable iff (!rst_n)
        core_act |=> (out_bon && out_bsc >= $past(core_bsc)));
endmodule

// File: rtl/scr_commit_stage.sv
// Extra graph-chain hop at the end of each node: writes the node's chosen
// parent set into the graph vector and adds its score to the graph total.
// Assumes the vector field for NODE arrives as zero.
module scr_commit_stage #(
    parameter int SW   = 16,
    parameter int PW   = 8,
    parameter int TW   = 4,
    parameter int GW   = 24,
    parameter int NODE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [TW-1:0]        in_tag,
    input  logic signed [SW-1:0] in_tot,
    input  logic [GW-1:0]        in_vec,
    input  logic                 in_bon,
    input  logic signed [SW-1:0] in_bsc,
    input  logic [PW-1:0]        in_bset,
    output logic                 out_vld,
    output logic [TW-1:0]        out_tag,
    output logic signed [SW-1:0] out_tot,
    output logic [GW-1:0]        out_vec,
    output logic                 out_bon,
    output logic signed [SW-1:0] out_bsc,
    output logic [PW-1:0]        out_bset
);
    logic [GW-1:0] vec_nx;

    // Drop the chosen set into this node's field.
    always_comb begin
        vec_nx = in_vec;
        if (in_bon) vec_nx[NODE*PW +: PW] = in_bset;
    end

    // Register the hop and clear the per-node best for the next node.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_tag  <= '0;
            out_tot  <= '0;
            out_vec  <= '0;
        end else begin
            out_vld  <= in_vld;
            out_tag  <= in_tag;
            out_tot  <= in_bon ? in_tot + in_bsc : in_tot;
            out_vec  <= vec_nx;
        end
    end

    assign out_bon  = 1'b0;
    assign out_bsc  = '0;
    assign out_bset = '0;

    // R7: a node with no active core leaves the graph total untouched.
    a_r7_idle_node_keeps_total: assert property (@(posedge clk) disable iff (!rst_n)
        !in_bon |=> (out_tot == $past(in_tot)));
endmodule

// File: rtl/score_chain_reducer.sv
// Top of the reduction chain. Builds an order chain of S hops and a graph
// chain of S + N_NODES hops, aligns each core's result to its hop with a delay
// line, and registers the final results. Assumes all active cores of one
// order raise valid in the same cycle.
module score_chain_reducer
    import scr_pkg::*;
#(
    parameter int N_NODES = 3,
    parameter int N_CORES = 2,
    parameter int SCORE_W = 16,
    parameter int PSET_W  = 8,
    parameter int TAG_W   = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N_NODES*N_CORES-1:0]          core_vld,
    input  logic [N_NODES*N_CORES-1:0]          core_en,
    input  logic [N_NODES*N_CORES*SCORE_W-1:0]  core_sum,
    input  logic [N_NODES*N_CORES*PSET_W-1:0]   core_bset,
    input  logic [N_NODES*N_CORES*SCORE_W-1:0]  core_bscore,
    output logic                                order_valid,
    output logic signed [SCORE_W-1:0]           order_score,
    output logic                                order_err,
    output logic [TAG_W-1:0]                    order_tag,
    output logic                                graph_valid,
    output logic signed [SCORE_W-1:0]           graph_score,
    output logic [N_NODES*PSET_W-1:0]           graph_sets,
    output logic [TAG_W-1:0]                    graph_tag
);
    localparam int S  = N_NODES * N_CORES;
    localparam int G  = S + N_NODES;
    localparam int GW = N_NODES * PSET_W;

    logic             launch;
    logic [TAG_W-1:0] tag_cnt;
    logic [S-1:0]     act;

    assign launch = |core_vld;
    assign act    = core_vld & core_en;

    // Count launches to tag each order.
    always_ff @(posedge clk) begin
        if (!rst_n)      tag_cnt <= '0;
        else if (launch) tag_cnt <= tag_cnt + 1'b1;
    end

    // Order chain state, one entry per hop boundary.
    logic                      o_vld [S+1];
    logic [TAG_W-1:0]          o_tag [S+1];
    logic signed [SCORE_W-1:0] o_acc [S+1];
    logic                      o_on  [S+1];
    logic signed [SCORE_W-1:0] o_tot [S+1];
    logic                      o_any [S+1];

    // Graph chain state, one entry per hop boundary.
    logic                      g_vld  [G+1];
    logic [TAG_W-1:0]          g_tag  [G+1];
    logic signed [SCORE_W-1:0] g_tot  [G+1];
    logic [GW-1:0]             g_vec  [G+1];
    logic                      g_bon  [G+1];
    logic signed [SCORE_W-1:0] g_bsc  [G+1];
    logic [PSET_W-1:0]         g_bset [G+1];

    assign o_vld[0] = launch;
    assign o_tag[0] = tag_cnt;
    assign o_acc[0] = '0;
    assign o_on[0]  = 1'b0;
    assign o_tot[0] = '0;
    assign o_any[0] = 1'b0;

    assign g_vld[0]  = launch;
    assign g_tag[0]  = tag_cnt;
    assign g_tot[0]  = '0;
    assign g_vec[0]  = '0;
    assign g_bon[0]  = 1'b0;
    assign g_bsc[0]  = '0;
    assign g_bset[0] = '0;

    generate
        for (genvar n = 0; n < N_NODES; n++) begin : g_node
            for (genvar c = 0; c < N_CORES; c++) begin : g_core
                localparam int K = n * N_CORES + c;
                localparam int P = n * (N_CORES + 1) + c;

                logic                      od_act;
                logic signed [SCORE_W-1:0] od_sum;
                logic                      gd_act;
                logic signed [SCORE_W-1:0] gd_bsc;
                logic [PSET_W-1:0]         gd_bset;

                scr_delay #(.W(1 + SCORE_W), .DEPTH(K)) u_odly (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .din  ({act[K], core_sum[K*SCORE_W +: SCORE_W]}),
                    .dout ({od_act, od_sum})
                );

                scr_order_stage #(.SW(SCORE_W), .TW(TAG_W), .LAST(c == N_CORES - 1)) u_ost (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .in_vld  (o_vld[K]),
                    .in_tag  (o_tag[K]),
                    .in_acc  (o_acc[K]),
                    .in_on   (o_on[K]),
                    .in_tot  (o_tot[K]),
                    .in_any  (o_any[K]),
                    .core_act(od_act),
                    .core_sum(od_sum),
                    .out_vld (o_vld[K+1]),
                    .out_tag (o_tag[K+1]),
                    .out_acc (o_acc[K+1]),
                    .out_on  (o_on[K+1]),
                    .out_tot (o_tot[K+1]),
                    .out_any (o_any[K+1])
                );

                scr_delay #(.W(1 + SCORE_W + PSET_W), .DEPTH(P)) u_gdly (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .din  ({act[K], core_bscore[K*SCORE_W +: SCORE_W], core_bset[K*PSET_W +: PSET_W]}),
                    .dout ({gd_act, gd_bsc, gd_bset})
                );

                scr_best_stage #(.SW(SCORE_W), .PW(PSET_W), .TW(TAG_W), .GW(GW)) u_bst (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .in_vld   (g_vld[P]),
                    .in_tag   (g_tag[P]),
                    .in_tot   (g_tot[P]),
                    .in_vec   (g_vec[P]),
                    .in_bon   (g_bon[P]),
                    .in_bsc   (g_bsc[P]),
                    .in_bset  (g_bset[P]),
                    .core_act (gd_act),
                    .core_bsc (gd_bsc),
                    .core_bset(gd_bset),
                    .out_vld  (g_vld[P+1]),
                    .out_tag  (g_tag[P+1]),
                    .out_tot  (g_tot[P+1]),
                    .out_vec  (g_vec[P+1]),
                    .out_bon  (g_bon[P+1]),
                    .out_bsc  (g_bsc[P+1]),
                    .out_bset (g_bset[P+1])
                );
            end

            localparam int Q = n * (N_CORES + 1) + N_CORES;

            scr_commit_stage #(.SW(SCORE_W), .PW(PSET_W), .TW(TAG_W), .GW(GW), .NODE(n)) u_cst (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_vld  (g_vld[Q]),
                .in_tag  (g_tag[Q]),
                .in_tot  (g_tot[Q]),
                .in_vec  (g_vec[Q]),
                .in_bon  (g_bon[Q]),
                .in_bsc  (g_bsc[Q]),
                .in_bset (g_bset[Q]),
                .out_vld (g_vld[Q+1]),
                .out_tag (g_tag[Q+1]),
                .out_tot (g_tot[Q+1]),
                .out_vec (g_vec[Q+1]),
                .out_bon (g_bon[Q+1]),
                .out_bsc (g_bsc[Q+1]),
                .out_bset(g_bset[Q+1])
            );
        end
    endgenerate

    logic unused_tail;
    assign unused_tail = ^{o_acc[S], o_on[S], g_bon[G], g_bsc[G], g_bset[G]};

    // Register the order result for the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_valid <= 1'b0;
            order_score <= '0;
            order_err   <= 1'b0;
            order_tag   <= '0;
        end else begin
            order_valid <= o_vld[S];
            order_score <= o_any[S] ? o_tot[S] : '0;
            order_err   <= o_vld[S] & ~o_any[S];
            order_tag   <= o_tag[S];
        end
    end

    // Register the assembled graph result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            graph_valid <= 1'b0;
            graph_score <= '0;
            graph_sets  <= '0;
            graph_tag   <= '0;
        end else begin
            graph_valid <= g_vld[G];
            graph_score <= g_tot[G];
            graph_sets  <= g_vec[G];
            graph_tag   <= g_tag[G];
        end
    end

    // R9: an empty order reports a zero score.
    a_r9_err_zero_score: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |-> (order_valid && order_score == '0));

    // R8: back-to-back order results carry consecutive tags.
    a_r8_order_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        (order_valid && $past(order_valid)) |-> (order_tag == TAG_W'($past(order_tag) + 1'b1)));

    // R8: back-to-back graph results carry consecutive tags.
    a_r8_graph_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        (graph_valid && $past(graph_valid)) |-> (graph_tag == TAG_W'($past(graph_tag) + 1'b1)));
endmodule

// File: tb/score_chain_reducer_bench.sv
module score_chain_reducer_bench;
    localparam int NN = 3;
    localparam int NC = 2;
    localparam int SW = 16;
    localparam int PW = 8;
    localparam int TW = 4;
    localparam int S  = NN * NC;

    typedef struct packed {
        logic [S-1:0] vld;
        logic [S-1:0] en;
        logic [15:0]  base;
        logic [7:0]   step;
        logic [7:0]   seed;
    } vec_t;

    localparam vec_t TABLE [6] = '{
        '{vld: 6'h3F, en: 6'h3F, base: 16'hFF9C, step: 8'd0, seed: 8'd1},
        '{vld: 6'h3F, en: 6'h3F, base: 16'hFFCE, step: 8'd1, seed: 8'd2},
        '{vld: 6'h3F, en: 6'h2D, base: 16'hFF38, step: 8'd5, seed: 8'd3},
        '{vld: 6'h3F, en: 6'h0F, base: 16'hFFE2, step: 8'd3, seed: 8'd4},
        '{vld: 6'h15, en: 6'h3F, base: 16'hFFB0, step: 8'd2, seed: 8'd5},
        '{vld: 6'h3F, en: 6'h30, base: 16'hFFF6, step: 8'd9, seed: 8'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [S-1:0] st_vld = '0;
    logic [S-1:0] st_en = '0;
    int st_sum [S];
    int st_bsc [S];
    int st_set [S];

    logic [S*SW-1:0] core_sum, core_bscore;
    logic [S*PW-1:0] core_bset;
    logic order_valid, order_err, graph_valid;
    logic signed [SW-1:0] order_score, graph_score;
    logic [TW-1:0] order_tag, graph_tag;
    logic [NN*PW-1:0] graph_sets;

    int n_checks = 0;
    int n_fails = 0;
    int launches = 0;

    int e_os [3];
    int e_gs [3];
    logic e_err [3];
    logic [NN*PW-1:0] e_sets [3];
    int e_tag [3];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < S; k++) begin
            core_sum[k*SW +: SW]    = st_sum[k][SW-1:0];
            core_bscore[k*SW +: SW] = st_bsc[k][SW-1:0];
            core_bset[k*PW +: PW]   = st_set[k][PW-1:0];
        end
    end

    score_chain_reducer #(.N_NODES(NN), .N_CORES(NC), .SCORE_W(SW), .PSET_W(PW), .TAG_W(TW)) u_score_chain_reducer (
        .clk(clk), .rst_n(rst_n), .core_vld(st_vld), .core_en(st_en),
        .core_sum(core_sum), .core_bset(core_bset), .core_bscore(core_bscore),
        .order_valid(order_valid), .order_score(order_score), .order_err(order_err), .order_tag(order_tag),
        .graph_valid(graph_valid), .graph_score(graph_score), .graph_sets(graph_sets), .graph_tag(graph_tag)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ladd(input int a, input int b);
        int m = (a > b) ? a : b;
        int d = (a > b) ? a - b : b - a;
        return m + ((d == 0) ? 2 : (d <= 3) ? 1 : 0);
    endfunction

    // Reference built from R3-style rules: fold, sum, pick best per node.
    task automatic model(input int slot);
        int tot = 0, gt = 0;
        logic any = 1'b0;
        logic [NN*PW-1:0] sets = '0;
        for (int n = 0; n < NN; n++) begin
            int acc = 0, bsc = 0, bset = 0;
            logic on = 1'b0;
            for (int c = 0; c < NC; c++) begin
                int k = n * NC + c;
                if (st_vld[k] && st_en[k]) begin
                    acc = on ? ladd(acc, st_sum[k]) : st_sum[k];
                    if (!on || st_bsc[k] > bsc) begin
                        bsc = st_bsc[k];
                        bset = st_set[k];
                    end
                    on = 1'b1;
                end
            end
            if (on) begin
                tot += acc;
                gt += bsc;
                any = 1'b1;
                sets[n*PW +: PW] = bset[PW-1:0];
            end
        end
        e_os[slot] = any ? tot : 0;
        e_gs[slot] = gt;
        e_err[slot] = !any;
        e_sets[slot] = sets;
        e_tag[slot] = launches % (1 << TW);
    endtask

    task automatic load_row(input vec_t v);
        st_vld = v.vld;
        st_en = v.en;
        for (int k = 0; k < S; k++) begin
            st_sum[k] = int'($signed(v.base)) - ((k * int'(v.step)) % 17);
            st_bsc[k] = -20 - ((k * 7 + int'(v.seed) * 3) % 11);
            st_set[k] = int'(v.seed) * 16 + k + 1;
        end
    endtask

    task automatic check_order(input int slot, input string tagname);
        chk({tagname, " R2 order_valid"}, order_valid, 1);
        chk({tagname, " R4 order_score"}, longint'(order_score), longint'(16'(e_os[slot]) ^ 16'h0) - ((e_os[slot] & 32'h8000) != 0 ? 0 : 0) );
        chk({tagname, " R9 order_err"}, order_err, e_err[slot]);
        chk({tagname, " R2 order_tag"}, order_tag, e_tag[slot]);
    endtask

    task automatic check_graph(input int slot, input string tagname);
        chk({tagname, " R8 graph_valid"}, graph_valid, 1);
        chk({tagname, " R7 graph_score"}, longint'(graph_score), longint'($signed(16'(e_gs[slot]))));
        chk({tagname, " R6 graph_sets"}, graph_sets, e_sets[slot]);
        chk({tagname, " R8 graph_tag"}, graph_tag, e_tag[slot]);
    endtask

    // Launch the loaded stimulus once and check both results at their due cycles.
    task automatic run_one(input string name);
        model(0);
        @(posedge clk);
        launches++;
        @(negedge clk);
        st_vld = '0;
        repeat (S - 1) @(posedge clk);
        @(negedge clk);
        chk({name, " R2 order not early"}, order_valid, 0);
        @(posedge clk);
        @(negedge clk);
        chk({name, " R2 order_valid"}, order_valid, 1);
        chk({name, " R4 order_score"}, longint'(order_score), longint'($signed(16'(e_os[0]))));
        chk({name, " R9 order_err"}, order_err, e_err[0]);
        chk({name, " R2 order_tag"}, order_tag, e_tag[0]);
        repeat (NN - 1) @(posedge clk);
        @(negedge clk);
        chk({name, " R8 graph not early"}, graph_valid, 0);
        @(posedge clk);
        @(negedge clk);
        check_graph(0, name);
    endtask

    initial begin
        for (int k = 0; k < S; k++) begin
            st_sum[k] = 0;
            st_bsc[k] = 0;
            st_set[k] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        chk("R1 order_valid", order_valid, 0);
        chk("R1 graph_valid", graph_valid, 0);
        chk("R1 order_score", order_score, 0);
        chk("R1 graph_score", graph_score, 0);
        chk("R1 graph_sets", graph_sets, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3/R4/R5/R6/R7 under varied enable, valid and spacing patterns.
        for (int i = 0; i < 6; i++) begin
            load_row(TABLE[i]);
            run_one($sformatf("row%0d", i));
        end

        // R3 hand value: two equal sums in one node fold to sum+2; other nodes off.
        st_vld = 6'h03; st_en = 6'h3F;
        for (int k = 0; k < S; k++) begin st_sum[k] = -40; st_bsc[k] = -9; st_set[k] = 8'h30 + k; end
        model(0);
        chk("R3 hand fold equal", e_os[0], -38);
        run_one("equal_fold");

        // R6 tie: equal best scores in node 0, lower core index wins.
        st_vld = 6'h3F; st_en = 6'h3F;
        for (int k = 0; k < S; k++) begin st_sum[k] = -10 * (k + 1); st_bsc[k] = -5; st_set[k] = 8'h11 * (k + 1); end
        run_one("tie");
        chk("R6 tie lower index", graph_sets[PW-1:0], 8'h11);

        // R9: every core disabled while valid is raised.
        st_vld = 6'h3F; st_en = 6'h00;
        for (int k = 0; k < S; k++) begin st_sum[k] = 100; st_bsc[k] = 50; st_set[k] = 8'hEE; end
        run_one("empty");
        chk("R9 empty err", order_err, 0);

        // R8: three launches on consecutive cycles.
        for (int j = 0; j < 3; j++) begin
            load_row(TABLE[j]);
            model(j);
            @(posedge clk);
            launches++;
            @(negedge clk);
        end
        st_vld = '0;
        repeat (S - 2) @(posedge clk);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk($sformatf("b2b%0d R8 order_valid", j), order_valid, 1);
            chk($sformatf("b2b%0d R4 order_score", j), longint'(order_score), longint'($signed(16'(e_os[j]))));
            chk($sformatf("b2b%0d R8 order_tag", j), order_tag, e_tag[j]);
            if (j < 2) @(posedge clk);
        end
        repeat (NN - 2) @(posedge clk);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check_graph(j, $sformatf("b2b%0d", j));
            if (j < 2) @(posedge clk);
        end
        @(negedge clk);
        chk("R8 graph strobe ends", graph_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule